// File: doc/BRIEF.md
# Wide Register Write Collector

This block lets a host with a 32-bit write path update control registers that are 128 bits wide without exposing half-written values. Host dword writes aimed at the lower three lanes of a register are parked in a single staging collector. Nothing reaches the register until the host writes the most significant lane. That write moves the whole 128-bit word into the register in one step.

The collector serves one register at a time. It records which of its three lanes hold data and which register they belong to. A lower-lane write aimed at another register while the collector is in use is dropped. A commit fills any lane the collector does not hold for that register with zeros, then empties the collector. An access flagged as a 64-bit write is not supported and is ignored outright. Each register is brought out on a read-back bus so that its contents can be observed.

Top module: `wide_reg_collector`

## Requirements
- R1: After reset every register reads zero and the collector holds nothing, so a top-lane write with no lower-lane writes before it yields zeros in bits 95:0.
- R2: `wr_addr` is a dword address. Bits 1:0 select the lane: 0 is bits 31:0, 1 is bits 63:32, 2 is bits 95:64 and 3 is bits 127:96. The bits above them select the register index.
- R3: A write to lane 0, 1 or 2 stores its data in the collector when the collector is empty or already belongs to the same register. The register bank is not changed by it.
- R4: A write to lane 3 always commits. The register at the written index takes `wr_data` in bits 127:96 together with the collector's lanes for bits 95:0, and it reads back the new value from the next clock edge on.
- R5: On a commit, each of lanes 0..2 that the collector does not hold for that register is written as zero.
- R6: A write to lane 0, 1 or 2 of a register other than the one the collector holds data for is discarded, and the collector keeps its contents.
- R7: A commit empties the collector and releases its owning register, so the next commit without lower-lane writes gives zeros in bits 95:0.
- R8: A write with `wr_qword` high changes neither the collector nor any register, whatever its lane.
- R9: A lane-3 write to a register other than the collector's owner commits that register with bits 95:0 zero, and the data that was held is dropped.
- R10: Writing a lane that the collector already holds for the same register replaces the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_qword | input | 1 | Marks the write as a 64-bit access, which is ignored |
| wr_addr | input | IDX_W+2 | Dword address: register index above a 2-bit lane select |
| wr_data | input | 32 | Write data for the addressed lane |
| rd_flat | output | NUM_REGS*128 | Read-back of all registers; register r is at bits r*128 +: 128 |

## Verification
The bench builds the block with NUM_REGS = 4, so the register index field is two bits wide. A full sweep is then small enough to run. For each of the four registers, it tries all eight subsets of lower lanes held before the commit, in two passes with different data. Every zero-fill pattern is checked against every register, and each commit also checks that the other three registers are unchanged. Directed sequences add the conflict cases that a single register cannot show: a foreign lower-lane write, a foreign top-lane write, ignored 64-bit accesses and lane overwrites.

// File: rtl/wc_pkg.sv
package wc_pkg;
    localparam int DW      = 32;
    localparam int LANES   = 4;
    localparam int HELD    = LANES - 1;
    localparam int REG_W   = DW * LANES;
    localparam int LANE_W  = 2;
    localparam logic [LANE_W-1:0] TOP_LANE = 2'd3;
endpackage

// File: rtl/wc_addr_decode.sv
module wc_addr_decode
    import wc_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                    wr_en,
    input  logic                    wr_qword,
    input  logic [IDX_W+LANE_W-1:0] wr_addr,
    output logic                    low_acc,
    output logic                    top_acc,
    output logic [LANE_W-1:0]       lane,
    output logic [IDX_W-1:0]        idx
);
    logic in_range;
    logic take;

    generate
        if ((2 ** IDX_W) == NUM_REGS) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_partial
            assign in_range = (int'(wr_addr[IDX_W+LANE_W-1:LANE_W]) < NUM_REGS);
        end
    endgenerate

    always_comb begin
        lane    = wr_addr[LANE_W-1:0];
        idx     = wr_addr[IDX_W+LANE_W-1:LANE_W];
        take    = wr_en && !wr_qword && in_range;
        top_acc = take && (lane == TOP_LANE);
        low_acc = take && (lane != TOP_LANE);
    end
endmodule

// File: rtl/wc_collector.sv
module wc_collector
    import wc_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_acc,
    input  logic              top_acc,
    input  logic [LANE_W-1:0] lane,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DW-1:0]     wr_data,
    output logic              commit_vld,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [REG_W-1:0]  commit_val
);
    typedef struct packed {
        logic [HELD-1:0][DW-1:0] data;
        logic [HELD-1:0]         vld;
        logic [IDX_W-1:0]        owner;
    } coll_t;

    coll_t coll_d, coll_q;
    logic  same_owner;
    logic  busy_other;

    always_comb begin
        coll_d     = coll_q;
        same_owner = (coll_q.owner == idx);
        busy_other = (|coll_q.vld) && !same_owner;

        commit_vld = top_acc;
        commit_idx = idx;
        commit_val = '0;
        for (int i = 0; i < HELD; i++) begin
            if (coll_q.vld[i] && same_owner) begin
                commit_val[i*DW +: DW] = coll_q.data[i];
            end
        end
        commit_val[HELD*DW +: DW] = wr_data;

        if (top_acc) begin
            coll_d = '0;
        end else if (low_acc && !busy_other) begin
            for (int i = 0; i < HELD; i++) begin
                if (lane == LANE_W'(i)) begin
                    coll_d.data[i] = wr_data;
                    coll_d.vld[i]  = 1'b1;
                end
            end
            coll_d.owner = idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coll_q <= '0;
        end else begin
            coll_q <= coll_d;
        end
    end

    // R7
    commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_acc |=> (coll_q.vld == '0));

    // R6
    discard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_acc && (|coll_q.vld) && (coll_q.owner != idx)) |=> $stable(coll_q));

    // R3
    low_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_acc && ((coll_q.vld == '0) || (coll_q.owner == idx)))
        |=> (coll_q.owner == $past(idx)) && ($countones(coll_q.vld) >= 1));

    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_acc && (coll_q.vld == '0)) |-> (commit_val[HELD*DW-1:0] == '0));
endmodule

// File: rtl/wc_regbank.sv
module wc_regbank
    import wc_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_vld,
    input  logic [IDX_W-1:0]          commit_idx,
    input  logic [REG_W-1:0]          commit_val,
    output logic [NUM_REGS*REG_W-1:0] rd_flat
);
    logic [NUM_REGS-1:0][REG_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (commit_vld && (int'(commit_idx) == r)) begin
                regs_d[r] = commit_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_rd
            assign rd_flat[g*REG_W +: REG_W] = regs_q[g];
        end
    endgenerate

    // R3
    no_commit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_vld |=> $stable(regs_q));
endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
    import wc_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_qword,
    input  logic [IDX_W+LANE_W-1:0]   wr_addr,
    input  logic [DW-1:0]             wr_data,
    output logic [NUM_REGS*REG_W-1:0] rd_flat
);
    logic              low_acc;
    logic              top_acc;
    logic [LANE_W-1:0] lane;
    logic [IDX_W-1:0]  idx;
    logic              commit_vld;
    logic [IDX_W-1:0]  commit_idx;
    logic [REG_W-1:0]  commit_val;

    wc_addr_decode #(.NUM_REGS(NUM_REGS)) i_decode (
        .wr_en    (wr_en),
        .wr_qword (wr_qword),
        .wr_addr  (wr_addr),
        .low_acc  (low_acc),
        .top_acc  (top_acc),
        .lane     (lane),
        .idx      (idx)
    );

    wc_collector #(.NUM_REGS(NUM_REGS)) i_collector (
        .clk        (clk),
        .rst_n      (rst_n),
        .low_acc    (low_acc),
        .top_acc    (top_acc),
        .lane       (lane),
        .idx        (idx),
        .wr_data    (wr_data),
        .commit_vld (commit_vld),
        .commit_idx (commit_idx),
        .commit_val (commit_val)
    );

    wc_regbank #(.NUM_REGS(NUM_REGS)) i_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_vld (commit_vld),
        .commit_idx (commit_idx),
        .commit_val (commit_val),
        .rd_flat    (rd_flat)
    );

    // R8
    qword_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_qword) |=> $stable(rd_flat));

    // R4
    top_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_qword && (wr_addr[LANE_W-1:0] == TOP_LANE)) |-> commit_vld);
endmodule

// File: tb/test_wide_reg_collector.sv
module test_wide_reg_collector;
    localparam int NR = 4;
    localparam int AW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            wr_qword = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [NR*128-1:0] rd_flat;

    int n_chk = 0;
    int n_fail = 0;
    logic [127:0] exp_r [NR];

    always #2.5 clk = ~clk;

    wide_reg_collector #(.NUM_REGS(NR)) i_wide_reg_collector (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_qword(wr_qword),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_flat(rd_flat)
    );

    function automatic logic [31:0] pat(int r, int l, int p);
        return {8'(r + 8'hA0), 8'(l + 8'h10), 16'(p * 16'h0101 + 16'h0033)};
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic chk_all(string tag);
        for (int r = 0; r < NR; r++) chk(tag, rd_flat[r*128 +: 128], exp_r[r]);
    endtask

    task automatic wr(int r, int l, logic [31:0] d, bit q = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_qword = q; wr_addr = {2'(r), 2'(l)}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_qword = 1'b0;
    endtask

    initial begin
        #(5ns * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) exp_r[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset value");
        // R1: collector empty after reset -> zero fill
        wr(2, 3, 32'hCAFE0001);
        exp_r[2] = {32'hCAFE0001, 96'h0};
        chk_all("R1 empty collector after reset");

        // R2 R4 R5: sweep every register and every held-lane subset
        for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < NR; r++) begin
                for (int m = 0; m < 8; m++) begin
                    logic [127:0] e;
                    e = '0;
                    for (int l = 0; l < 3; l++) begin
                        if (m[l]) begin
                            wr(r, l, pat(r, l, p));
                            e[l*32 +: 32] = pat(r, l, p);
                        end
                    end
                    chk_all("R3 lower writes leave registers unchanged");
                    e[127:96] = pat(r, 3, p + m);
                    wr(r, 3, pat(r, 3, p + m));
                    exp_r[r] = e;
                    chk_all("R4 R5 R2 commit value and lane placement");
                end
            end
        end

        // R6: foreign lower write is discarded
        wr(1, 0, 32'h11110000);
        wr(2, 1, 32'h22221111);
        wr(1, 2, 32'h11112222);
        chk_all("R6 no register change before commit");
        wr(1, 3, 32'h11113333);
        exp_r[1] = {32'h11113333, 32'h11112222, 32'h0, 32'h11110000};
        chk_all("R6 foreign write dropped, owner data kept");
        wr(2, 3, 32'h22223333);
        exp_r[2] = {32'h22223333, 96'h0};
        chk_all("R6 R7 dropped lane never reached its register");

        // R9: foreign top write zero fills and drops held data
        wr(0, 0, 32'h00AA00AA);
        wr(0, 2, 32'h00BB00BB);
        wr(3, 3, 32'h33330003);
        exp_r[3] = {32'h33330003, 96'h0};
        chk_all("R9 foreign top write commits zeros below");
        wr(0, 3, 32'h00CC00CC);
        exp_r[0] = {32'h00CC00CC, 96'h0};
        chk_all("R9 R7 held data dropped by foreign commit");

        // R8: qword accesses ignored, including lane 3
        wr(2, 1, 32'h2222BBBB);
        wr(2, 2, 32'hDEADBEEF, 1'b1);
        wr(2, 3, 32'hFEEDFACE, 1'b1);
        chk_all("R8 qword top access does not commit");
        wr(2, 3, 32'h2222CCCC);
        exp_r[2] = {32'h2222CCCC, 32'h0, 32'h2222BBBB, 32'h0};
        chk_all("R8 qword data never entered collector");

        // R10: overwrite of a held lane
        wr(3, 1, 32'h0000AAAA);
        wr(3, 1, 32'h0000BBBB);
        wr(3, 0, 32'h0000CCCC);
        wr(3, 0, 32'h0000DDDD);
        wr(3, 3, 32'h3333EEEE);
        exp_r[3] = {32'h3333EEEE, 32'h0, 32'h0000BBBB, 32'h0000DDDD};
        chk_all("R10 last write to a lane wins");

        // R7: collector empty after commit
        wr(3, 3, 32'h3333FFFF);
        exp_r[3] = {32'h3333FFFF, 96'h0};
        chk_all("R7 back-to-back commit zero fills");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule